// File: doc/BRIEF.md
# Handshake Register Slave for Cell Processing Control

This block is the control and status register slave for a cell receive/transmit datapath. It sits on a small synchronous internal bus. The bus has separate 16-bit write and read data, a 7-bit word address, a read/write flag, a select input and an acknowledge output. The block drives the datapath enables, the idle-cell header and the idle payload byte. It also exposes a loss-of-delineation status bit and a set of event counters. The counters saturate and clear when read, and their increment pulses arrive from the datapath.

The handshake has four phases. The master raises select and waits for acknowledge. It then drops select, and acknowledge stays high until the slave has seen select fall. Select passes through a two-flop synchronizer before any logic uses it, so the master may run on a clock unrelated to this block. While acknowledge is low, read data and acknowledge are both zero. This lets the outputs of several slaves be merged with a plain OR.

The word address map is:

| Word | Contents |
|---|---|
| 0 | Control |
| 1 | Idle header, upper half |
| 2 | Idle header, lower half |
| 3 | Idle payload byte |
| 4 | Status |
| 8 upward | One counter per word |

Top module: `csr_hs_slave`

## Requirements
- R1: After select rises with the slave idle, acknowledge is 0 after two clock edges and 1 after the third edge. It stays 1 while select is held.
- R2: After select falls, acknowledge stays 1 through two more clock edges and returns to 0 on the third edge.
- R3: Read data is zero whenever acknowledge is 0. While acknowledge is 1, read data holds one value: the addressed word for a read, zero for a write.
- R4: A write takes effect exactly once per select assertion, with the data present when acknowledge rises. Changes to write data later in the same assertion are ignored.
- R5: Control word 0 has six enables, each reset to 0: bit 0 HEC correction, bit 1 HEC detection, bit 2 scrambling, bit 3 descrambling, bit 4 HEC insertion, bit 5 OAM filtering. Bits 15:6 read as 0.
- R6: Words 1 and 2 hold the upper and lower 16 bits of the 32-bit idle-cell header output. The header resets to 0x00000001.
- R7: Word 3 bits 7:0 hold the idle payload byte, which resets to 0x6A. Bits 15:8 read as 0.
- R8: Word 4 bit 0 returns the loss-of-delineation input as sampled when acknowledge rises. The other bits read as 0.
- R9: Counter i is at word 8+i. It is 16 bits wide and counts one per clock edge on which its increment bit is 1. It saturates at 0xFFFF.
- R10: Reading a counter returns its value and clears it. An increment on the clearing edge is kept, so the counter then holds 1.
- R11: Unmapped words read as 0 and ignore writes. Writes to the status and counter words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Access select, may be asynchronous |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 7 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero while not acknowledged |
| ack_o | output | 1 | Access acknowledge, four-phase |
| lcd_i | input | 1 | Loss-of-delineation status |
| cnt_inc_i | input | 4 | Counter increment pulses |
| hec_corr_en_o | output | 1 | HEC correction enable |
| hec_det_en_o | output | 1 | HEC detection enable |
| scr_en_o | output | 1 | Scrambler enable |
| descr_en_o | output | 1 | Descrambler enable |
| hec_ins_en_o | output | 1 | HEC insertion enable |
| oam_filt_en_o | output | 1 | OAM cell filter enable |
| idle_hdr_o | output | 32 | Idle cell header |
| idle_pl_o | output | 8 | Idle payload byte |

## Verification
Select is driven on the falling clock edge. Acknowledge is due on the third rising edge after select rises, and its fall is due on the third rising edge after select drops. The driver therefore checks acknowledge just before that edge and again just after it.

Read data and any register side effect land on the same edge as the acknowledge rise. A monitor waits for acknowledge to rise and samples read data at the next falling edge, comparing it against the item the driver queued.

Counter clears are timed by raising an increment bit only across that acknowledge edge. Saturation is reached by holding an increment bit past 65535 edges.

// File: rtl/csr_hs_pkg.sv
package csr_hs_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL     = 7'd0;
  localparam logic [ADDR_W-1:0] A_HDR_HI   = 7'd1;
  localparam logic [ADDR_W-1:0] A_HDR_LO   = 7'd2;
  localparam logic [ADDR_W-1:0] A_IDLE_PL  = 7'd3;
  localparam logic [ADDR_W-1:0] A_STATUS   = 7'd4;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 7'd8;

  typedef struct packed {
    logic oam_filt;
    logic hec_ins;
    logic descr;
    logic scr;
    logic hec_det;
    logic hec_corr;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [31:0] HDR_RST = 32'h0000_0001;
  localparam logic [7:0]  PL_RST  = 8'h6A;
endpackage

// File: rtl/hs_sync.sv
module hs_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic access_o,
  output logic ack_o
);
  logic s1_q, s2_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      s1_q  <= sel_i;
      s2_q  <= s1_q;
      ack_q <= s2_q;
    end
  end

  // one pulse per synchronized select assertion
  assign access_o = s2_q & ~ack_q;
  assign ack_o    = ack_q;

  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && !s2_q) |=> !ack_q); // R2
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX); // R9
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o <= CNT_W'(1)); // R10
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_hs_pkg::*;
#(
  parameter int NCNT  = 4,
  parameter int CNT_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       lcd_i,
  input  logic [NCNT-1:0][CNT_W-1:0] cnt_i,
  output ctrl_t                      ctrl_o,
  output logic [31:0]                hdr_o,
  output logic [7:0]                 pl_o,
  output logic [DATA_W-1:0]          rmux_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      hdr_o  <= HDR_RST;
      pl_o   <= PL_RST;
    end else if (we_i) begin
      unique case (addr_i)
        A_CTRL:    ctrl_o        <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        A_HDR_HI:  hdr_o[31:16]  <= wdata_i;
        A_HDR_LO:  hdr_o[15:0]   <= wdata_i;
        A_IDLE_PL: pl_o          <= wdata_i[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rmux_o = '0;
    unique case (addr_i)
      A_CTRL:    rmux_o = DATA_W'(ctrl_o);
      A_HDR_HI:  rmux_o = hdr_o[31:16];
      A_HDR_LO:  rmux_o = hdr_o[15:0];
      A_IDLE_PL: rmux_o = DATA_W'(pl_o);
      A_STATUS:  rmux_o = DATA_W'(lcd_i);
      default: begin
        for (int i = 0; i < NCNT; i++)
          if (addr_i == ADDR_W'(A_CNT_BASE + i)) rmux_o = DATA_W'(cnt_i[i]);
      end
    endcase
  end

  AST_WR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i); // R4
endmodule

// File: rtl/csr_hs_slave.sv
module csr_hs_slave
  import csr_hs_pkg::*;
#(
  parameter int NCNT  = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic [6:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              ack_o,
  input  logic              lcd_i,
  input  logic [NCNT-1:0]   cnt_inc_i,
  output logic              hec_corr_en_o,
  output logic              hec_det_en_o,
  output logic              scr_en_o,
  output logic              descr_en_o,
  output logic              hec_ins_en_o,
  output logic              oam_filt_en_o,
  output logic [31:0]       idle_hdr_o,
  output logic [7:0]        idle_pl_o
);
  logic                       access, ack_q;
  logic                       we;
  logic [NCNT-1:0]            clr;
  logic [NCNT-1:0][CNT_W-1:0] cnt;
  logic [DATA_W-1:0]          rmux, rdata_q;
  ctrl_t                      ctrl;

  hs_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .access_o (access),
    .ack_o    (ack_q)
  );

  assign we = access & ~rd_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    assign clr[g] = access & rd_i & (addr_i == ADDR_W'(A_CNT_BASE + g));
    evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc_i[g]),
      .clr_i  (clr[g]),
      .cnt_o  (cnt[g])
    );
  end

  csr_regs #(.NCNT(NCNT), .CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .lcd_i   (lcd_i),
    .cnt_i   (cnt),
    .ctrl_o  (ctrl),
    .hdr_o   (idle_hdr_o),
    .pl_o    (idle_pl_o),
    .rmux_o  (rmux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (access) rdata_q <= rd_i ? rmux : '0;
  end

  // zero while idle so slaves can be OR-merged
  assign rdata_o = ack_q ? rdata_q : '0;
  assign ack_o   = ack_q;

  assign hec_corr_en_o = ctrl.hec_corr;
  assign hec_det_en_o  = ctrl.hec_det;
  assign scr_en_o      = ctrl.scr;
  assign descr_en_o    = ctrl.descr;
  assign hec_ins_en_o  = ctrl.hec_ins;
  assign oam_filt_en_o = ctrl.oam_filt;

  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(sel_i, 3) && $past(sel_i, 2))); // R1
  AST_ACK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (!$past(sel_i, 3) && !$past(sel_i, 2))); // R2
  AST_RDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> $stable(rdata_o)); // R3
endmodule

// File: tb/tb_csr_hs_slave.sv
module tb_csr_hs_slave;
  localparam int NCNT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        sel_i = 0, rd_i = 0, lcd_i = 0;
  logic [6:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [NCNT-1:0] cnt_inc_i = '0;
  logic [15:0] rdata_o;
  logic        ack_o;
  logic hec_corr, hec_det, scr, descr, hec_ins, oam_filt;
  logic [31:0] idle_hdr;
  logic [7:0]  idle_pl;

  csr_hs_slave #(.NCNT(NCNT), .CNT_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o), .lcd_i(lcd_i),
    .cnt_inc_i(cnt_inc_i), .hec_corr_en_o(hec_corr), .hec_det_en_o(hec_det),
    .scr_en_o(scr), .descr_en_o(descr), .hec_ins_en_o(hec_ins),
    .oam_filt_en_o(oam_filt), .idle_hdr_o(idle_hdr), .idle_pl_o(idle_pl)
  );

  wire [5:0] ctrl_pins = {oam_filt, hec_ins, descr, scr, hec_det, hec_corr};

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one four-phase access, expected read data queued for the monitor
  task automatic access(input bit rd, input logic [6:0] a, input logic [15:0] wd,
                        input logic [15:0] exp, input string tag,
                        input int hold = 0, input logic [15:0] late_wd = '0,
                        input logic [NCNT-1:0] inc_at_ack = '0);
    logic [15:0] first;
    q.push_back('{exp, tag});
    @(negedge clk);
    rd_i = rd; addr_i = a; wdata_i = wd; sel_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(ack_o == 1'b0, "R1 ack early", ack_o, 0);
    chk(rdata_o == 16'h0, "R3 rdata idle", rdata_o, 0);
    cnt_inc_i = inc_at_ack;
    @(negedge clk);
    cnt_inc_i = '0;
    chk(ack_o == 1'b1, "R1 ack due", ack_o, 1);
    first = rdata_o;
    if (hold > 0) wdata_i = late_wd;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(ack_o == 1'b1 && rdata_o == first, "R3 rdata stable", rdata_o, first);
    end
    sel_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(ack_o == 1'b1, "R2 ack held", ack_o, 1);
    @(negedge clk);
    chk(ack_o == 1'b0, "R2 ack release", ack_o, 0);
    chk(rdata_o == 16'h0, "R3 rdata released", rdata_o, 0);
  endtask

  // monitor: compare data on each acknowledge
  initial begin
    item_t it;
    forever begin
      @(posedge ack_o);
      @(negedge clk);
      if (q.size() == 0) chk(1'b0, "R3 unexpected ack", ack_o, 0);
      else begin
        it = q.pop_front();
        chk(rdata_o == it.exp, it.tag, rdata_o, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack_o == 0 && rdata_o == 0, "reset R1 R3 idle outputs", {ack_o, rdata_o}, 0);
    chk(ctrl_pins == 6'h00, "reset R5 ctrl", ctrl_pins, 0);
    chk(idle_hdr == 32'h1, "reset R6 header", idle_hdr, 32'h1);
    chk(idle_pl == 8'h6A, "reset R7 payload", idle_pl, 8'h6A);

    access(1, 7'd0, 0, 16'h0000, "R5 ctrl reset read");
    access(0, 7'd0, 16'h002A, 16'h0000, "R3 write returns zero");
    chk(ctrl_pins == 6'h2A && hec_det && descr && oam_filt, "R5 ctrl pins", ctrl_pins, 6'h2A);
    access(1, 7'd0, 0, 16'h002A, "R5 ctrl readback");
    access(0, 7'd0, 16'hFFFF, 16'h0000, "R5 ctrl write all");
    access(1, 7'd0, 0, 16'h003F, "R5 ctrl upper bits zero");

    access(0, 7'd0, 16'h0005, 16'h0000, "R4 write once", 4, 16'h003A);
    chk(ctrl_pins == 6'h05, "R4 late wdata ignored", ctrl_pins, 6'h05);
    access(1, 7'd0, 0, 16'h0005, "R4 ctrl after late change");

    access(0, 7'd1, 16'h1234, 16'h0000, "R6 hdr hi write");
    access(0, 7'd2, 16'h5678, 16'h0000, "R6 hdr lo write");
    chk(idle_hdr == 32'h1234_5678, "R6 header pins", idle_hdr, 32'h1234_5678);
    access(1, 7'd1, 0, 16'h1234, "R6 hdr hi read");
    access(1, 7'd2, 0, 16'h5678, "R6 hdr lo read", 3);

    access(0, 7'd3, 16'hABCD, 16'h0000, "R7 payload write");
    chk(idle_pl == 8'hCD, "R7 payload pins", idle_pl, 8'hCD);
    access(1, 7'd3, 0, 16'h00CD, "R7 payload read");

    lcd_i = 1'b1;
    access(1, 7'd4, 0, 16'h0001, "R8 status set");
    lcd_i = 1'b0;
    access(1, 7'd4, 0, 16'h0000, "R8 status clear");

    @(negedge clk); cnt_inc_i[0] = 1'b1;
    repeat (10) @(negedge clk);
    cnt_inc_i[0] = 1'b0;
    access(1, 7'd8, 0, 16'd10, "R9 counter0 count");
    access(1, 7'd8, 0, 16'd0, "R10 counter0 cleared");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cnt_inc_i[2] = 1'b1;
      @(negedge clk); cnt_inc_i[2] = 1'b0;
      @(negedge clk);
    end
    access(1, 7'd10, 0, 16'd3, "R9 counter2 pulses");
    access(1, 7'd9, 0, 16'd0, "R9 counter1 untouched");

    access(1, 7'd11, 0, 16'd0, "R10 counter3 clear with inc", 0, '0, 4'b1000);
    access(1, 7'd11, 0, 16'd1, "R10 inc on clear edge kept");

    access(0, 7'd5, 16'hFFFF, 16'h0000, "R11 unmapped write");
    access(1, 7'd5, 0, 16'h0000, "R11 unmapped read");
    access(1, 7'h7F, 0, 16'h0000, "R11 top word read");
    access(0, 7'd8, 16'h1234, 16'h0000, "R11 counter write");
    access(1, 7'd8, 0, 16'h0000, "R11 counter unchanged");
    access(0, 7'd4, 16'hFFFF, 16'h0000, "R11 status write");
    access(1, 7'd4, 0, 16'h0000, "R11 status unchanged");
    access(1, 7'd0, 0, 16'h0005, "R11 ctrl unchanged");
    chk(idle_hdr == 32'h1234_5678 && idle_pl == 8'hCD, "R11 pins unchanged", idle_pl, 8'hCD);

    @(negedge clk); cnt_inc_i[1] = 1'b1;
    repeat (65600) @(negedge clk);
    cnt_inc_i[1] = 1'b0;
    access(1, 7'd9, 0, 16'hFFFF, "R9 counter1 saturated");
    access(1, 7'd9, 0, 16'h0000, "R10 cleared after saturation");

    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule